// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets any of `NUM_CORES` processor cores raise an interrupt at any core, itself included, and pass a 16-bit message with it. Each core has a single-slot mailbox. The slot holds a pending flag, the sending core's index and the last message. Software on a core writes a command word into its own control register. That one word can post a message to a destination core, retire the writer's own pending interrupt, or do both at once.

The register window gives every core an 8-byte pair: a writable control register and a read-only status register. Accesses are plain synchronous 32-bit reads and writes. Read data comes back on the clock after the request. Each core's interrupt output is a level taken straight from that core's registered pending flag. A newer message aimed at a core replaces the older one, and nothing is queued.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset, every control and status register reads as zero and every interrupt output is low.
- R2: Address bit 2 picks the register within a core's pair (0 control, 1 status), and bits 3 and up pick the core index. A control write stores the whole 32-bit word, and a later read of that control register returns it unchanged.
- R3: A control write with bit 30 set posts a message. Bits 29:16 name the destination and bits 15:0 are the payload. The destination's status becomes bit 30 set, bits 29:16 holding the writer's index, bits 15:0 holding the payload, and bit 31 clear. Its interrupt output is high from the clock after the write.
- R4: A control write with bit 31 set clears bit 30 of the writer's own status and drops the writer's interrupt output. The other status bits keep their values.
- R5: When one write sets both bit 30 and bit 31 and names the writer as destination, the post is applied first and the acknowledge second. The status then holds the new sender and payload with bit 30 clear, and the interrupt output is low.
- R6: A post to a core whose interrupt is still pending replaces the sender index and payload with the newest ones, and the interrupt stays high.
- R7: A post whose destination index is NUM_CORES or more changes no status register and raises no interrupt. The control word is still stored.
- R8: Writes to a status register address, and writes to a core index of NUM_CORES or more, change no register and no interrupt output.
- R9: Read data appears on the clock after the read request and holds while no read is requested. A read of a core index of NUM_CORES or more returns zero.
- R10: When one write sets both bits, names another core, and the writer has an interrupt pending, the writer's pending flag is cleared and the destination is posted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write request |
| reg_ren | input | 1 | Register read request |
| reg_addr | input | ADDR_W | Byte address within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid on the clock after a read request |
| irq_o | output | NUM_CORES | Level interrupt per core, high while its message is pending |

## Verification
The post command is tried in several ways: to another core, to an already pending core, to the writer itself together with an acknowledge, and together with an acknowledge to a different core. These cases separate the ordering of post and acknowledge, and they show whether a same-cycle acknowledge reaches the wrong slot. Destinations past the core count, writes to status addresses and writes to unpopulated core indices must leave every status word and interrupt output as they were. That shows whether the range checks and the bit-2 decode are wired correctly. Sender and payload fields use distinct non-symmetric values, so a swapped or shifted field shows up on readback.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int REG_W   = 32;
  localparam int ID_W    = 14;
  localparam int MSG_W   = 16;
  localparam int BIT_ACK = 31;
  localparam int BIT_PND = 30;

  // Control word layout: command bits on top, then destination, then message.
  typedef struct packed {
    logic             ack;
    logic             post;
    logic [ID_W-1:0]  dst;
    logic [MSG_W-1:0] msg;
  } ipi_cmd_t;

  // Status word built on a post: bit 31 zero, pending, sender, payload.
  function automatic logic [REG_W-1:0] f_status_word(
    input logic             pend,
    input logic [ID_W-1:0]  src,
    input logic [MSG_W-1:0] msg
  );
    return {1'b0, pend, src, msg};
  endfunction

  // Byte address of a core's register: core index above bit 2, register in bit 2.
  function automatic int unsigned f_core_index(input logic [63:0] addr);
    return int'(addr >> 3);
  endfunction

endpackage

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wen,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  output logic [NUM_CORES-1:0] ctrl_we,
  output logic [NUM_CORES-1:0] post_hit,
  output logic [NUM_CORES-1:0] ack_hit,
  output logic [ID_W-1:0]      src_id,
  output logic [MSG_W-1:0]     msg
);

  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             idx_ok;
  logic             ctrl_wr;
  logic             dst_ok;
  ipi_cmd_t         cmd;

  assign idx     = addr[ADDR_W-1:3];
  assign idx_ok  = f_core_index(64'(addr)) < NUM_CORES;
  assign ctrl_wr = wen && !addr[2] && idx_ok;
  assign cmd     = ipi_cmd_t'(wdata);
  assign dst_ok  = 32'(cmd.dst) < NUM_CORES;
  assign src_id  = ID_W'(idx);
  assign msg     = cmd.msg;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    assign ctrl_we[g]  = ctrl_wr && (idx == IDX_W'(g));
    assign post_hit[g] = ctrl_wr && cmd.post && dst_ok && (cmd.dst == ID_W'(g));
    assign ack_hit[g]  = ctrl_we[g] && cmd.ack;
  end

  // R3: a post reaches at most one mailbox
  a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(post_hit));

  // R8: status-register writes never reach any control register
  a_r8_status_wr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && addr[2]) |-> (ctrl_we == '0 && post_hit == '0));

  // R7: out-of-range destination posts nowhere
  a_r7_bad_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && !dst_ok) |-> (post_hit == '0));

endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
  import ipi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             post_hit,
  input  logic             ack_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic [ID_W-1:0]  src_id,
  input  logic [MSG_W-1:0] msg,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] stat_q,
  output logic             irq
);

  logic [REG_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (post_hit) stat_d = f_status_word(1'b1, src_id, msg);
    if (ack_hit)  stat_d[BIT_PND] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      stat_q <= stat_d;
    end
  end

  assign irq = stat_q[BIT_PND];

  // R3/R6: a post without acknowledge leaves the latest sender and payload pending
  a_r3_post_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (post_hit && !ack_hit) |=> (irq && stat_q[29:0] == {$past(src_id), $past(msg)}));

  // R4/R5: an acknowledge always leaves the line low
  a_r4_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> !irq);

  // R4: acknowledge alone keeps sender and payload
  a_r4_ack_keeps_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !post_hit) |=> (stat_q[29:0] == $past(stat_q[29:0])));

  // R8: no command, no status change
  a_r8_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!post_hit && !ack_hit) |=> $stable(stat_q));

  // R2: control stores the written word
  a_r2_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == $past(wdata)));

  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));

endmodule

// File: rtl/ipi_rd_port.sv
module ipi_rd_port
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ren,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_CORES-1:0][REG_W-1:0]  ctrl_all,
  input  logic [NUM_CORES-1:0][REG_W-1:0]  stat_all,
  output logic [REG_W-1:0]                 rdata
);

  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             idx_ok;
  logic [REG_W-1:0] sel;

  assign idx    = addr[ADDR_W-1:3];
  assign idx_ok = f_core_index(64'(addr)) < NUM_CORES;

  always_comb begin
    sel = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (idx_ok && idx == IDX_W'(c)) sel = addr[2] ? stat_all[c] : ctrl_all[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   rdata <= '0;
    else if (ren) rdata <= sel;
  end

  // R9: data holds between reads
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> $stable(rdata));

  // R9: unpopulated index reads zero
  a_r9_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ren && !idx_ok) |=> (rdata == '0));

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wen,
  input  logic                 reg_ren,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_CORES-1:0] irq_o
);

  logic [NUM_CORES-1:0]            ctrl_we;
  logic [NUM_CORES-1:0]            post_hit;
  logic [NUM_CORES-1:0]            ack_hit;
  logic [ID_W-1:0]                 src_id;
  logic [MSG_W-1:0]                msg;
  logic [NUM_CORES-1:0][REG_W-1:0] ctrl_all;
  logic [NUM_CORES-1:0][REG_W-1:0] stat_all;

  ipi_wr_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wen      (reg_wen),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .ctrl_we  (ctrl_we),
    .post_hit (post_hit),
    .ack_hit  (ack_hit),
    .src_id   (src_id),
    .msg      (msg)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    ipi_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (ctrl_we[g]),
      .post_hit (post_hit[g]),
      .ack_hit  (ack_hit[g]),
      .wdata    (reg_wdata),
      .src_id   (src_id),
      .msg      (msg),
      .ctrl_q   (ctrl_all[g]),
      .stat_q   (stat_all[g]),
      .irq      (irq_o[g])
    );
  end

  ipi_rd_port #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ren      (reg_ren),
    .addr     (reg_addr),
    .ctrl_all (ctrl_all),
    .stat_all (stat_all),
    .rdata    (reg_rdata)
  );

  // R1: interrupts low in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0));

  // R10: post and acknowledge land in different slots in the same cycle
  a_r10_cross: assert property (@(posedge clk) disable iff (!rst_n)
    ((post_hit & ack_hit) == '0 && post_hit != '0 && ack_hit != '0)
      |=> ((irq_o & $past(post_hit)) == $past(post_hit) && (irq_o & $past(ack_hit)) == '0));

endmodule

// File: tb/test_ipi_mailbox.sv
module test_ipi_mailbox;

  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wen;
  logic          reg_ren;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  irq_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  ipi_mailbox #(.NUM_CORES(N), .ADDR_W(AW)) i_ipi_mailbox (
    .clk, .rst_n, .reg_wen, .reg_ren, .reg_addr, .reg_wdata, .reg_rdata, .irq_o
  );

  function automatic logic [AW-1:0] mk_addr(input int core, input bit is_stat);
    return AW'((core << 3) | (int'(is_stat) << 2));
  endfunction

  function automatic logic [31:0] cmd(input bit ack, input bit post, input int dst, input logic [15:0] m);
    return {ack, post, 14'(dst), m};
  endfunction

  function automatic logic [31:0] stat(input bit pend, input int src, input logic [15:0] m);
    return {1'b0, pend, 14'(src), m};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int core, input bit is_stat, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = mk_addr(core, is_stat); reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input int core, input bit is_stat, output logic [31:0] d);
    @(negedge clk);
    reg_ren = 1'b1; reg_addr = mk_addr(core, is_stat);
    @(negedge clk);
    reg_ren = 1'b0;
    d = reg_rdata;
  endtask

  task automatic chk_stat(input string tag, input int core, input logic [31:0] exp);
    logic [31:0] d;
    rd(core, 1'b1, d);
    check(tag, d, exp);
  endtask

  task automatic chk_irq(input string tag, input logic [N-1:0] exp);
    check(tag, 32'(irq_o), 32'(exp));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk_irq("R1 irq after reset", '0);
    for (int c = 0; c < N; c++) begin
      rd(c, 1'b0, d); check("R1 ctrl after reset", d, 32'h0);
      rd(c, 1'b1, d); check("R1 status after reset", d, 32'h0);
    end
  endtask

  task automatic t_post;
    logic [31:0] d;
    wr(1, 1'b0, cmd(0, 1, 2, 16'hBEEF));
    chk_irq("R3 irq of destination", 4'b0100);
    chk_stat("R3 destination status", 2, stat(1, 1, 16'hBEEF));
    chk_stat("R3 sender status untouched", 1, 32'h0);
    rd(1, 1'b0, d); check("R2 control readback", d, 32'h4002BEEF);
  endtask

  task automatic t_ack;
    wr(2, 1'b0, cmd(1, 0, 0, 16'h0));
    chk_irq("R4 irq dropped", '0);
    chk_stat("R4 fields kept", 2, stat(0, 1, 16'hBEEF));
    wr(2, 1'b0, cmd(1, 0, 0, 16'h0));
    chk_stat("R4 repeat ack harmless", 2, stat(0, 1, 16'hBEEF));
  endtask

  task automatic t_overwrite;
    wr(0, 1'b0, cmd(0, 1, 3, 16'h1111));
    wr(1, 1'b0, cmd(0, 1, 3, 16'h2222));
    chk_irq("R6 still pending", 4'b1000);
    chk_stat("R6 newest message wins", 3, stat(1, 1, 16'h2222));
    wr(3, 1'b0, cmd(1, 0, 0, 16'h0));
    chk_stat("R4 ack after overwrite", 3, stat(0, 1, 16'h2222));
  endtask

  task automatic t_self_both;
    wr(0, 1'b0, cmd(1, 1, 0, 16'hABCD));
    chk_irq("R5 self post+ack leaves irq low", '0);
    chk_stat("R5 self post+ack status", 0, stat(0, 0, 16'hABCD));
  endtask

  task automatic t_cross_both;
    wr(1, 1'b0, cmd(0, 1, 3, 16'h0055));
    chk_irq("R10 setup pending", 4'b1000);
    wr(3, 1'b0, cmd(1, 1, 1, 16'h7777));
    chk_irq("R10 irq swap", 4'b0010);
    chk_stat("R10 writer cleared", 3, stat(0, 1, 16'h0055));
    chk_stat("R10 destination posted", 1, stat(1, 3, 16'h7777));
    wr(1, 1'b0, cmd(1, 0, 0, 16'h0));
    chk_irq("R4 final ack", '0);
  endtask

  task automatic t_bad_dst;
    logic [31:0] d;
    wr(0, 1'b0, cmd(0, 1, 4, 16'h9999));
    chk_irq("R7 dst=N no irq", '0);
    wr(2, 1'b0, cmd(0, 1, 16383, 16'h8888));
    chk_irq("R7 dst=max no irq", '0);
    chk_stat("R7 status0 unchanged", 0, stat(0, 0, 16'hABCD));
    chk_stat("R7 status2 unchanged", 2, stat(0, 1, 16'hBEEF));
    chk_stat("R7 status3 unchanged", 3, stat(0, 1, 16'h0055));
    rd(0, 1'b0, d); check("R7 control still stored", d, 32'h40049999);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    wr(2, 1'b1, cmd(0, 1, 2, 16'hFFFF));
    chk_irq("R8 status write no irq", '0);
    chk_stat("R8 status write ignored", 2, stat(0, 1, 16'hBEEF));
    wr(5, 1'b0, cmd(0, 1, 0, 16'h0001));
    chk_irq("R8 unpopulated core write no irq", '0);
    chk_stat("R8 status0 after unpopulated write", 0, stat(0, 0, 16'hABCD));
    rd(5, 1'b0, d); check("R9 unpopulated read zero", d, 32'h0);
  endtask

  task automatic t_read_timing;
    logic [31:0] d;
    rd(1, 1'b0, d);
    check("R9 read one clock later", d, 32'h80000000);
    wr(1, 1'b0, 32'h00001234);
    @(negedge clk);
    check("R9 rdata holds without read", reg_rdata, 32'h80000000);
    rd(1, 1'b0, d);
    check("R2 control new value", d, 32'h00001234);
  endtask

  initial begin
    rst_n = 1'b0; reg_wen = 1'b0; reg_ren = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_post();
    t_ack();
    t_overwrite();
    t_self_both();
    t_cross_both();
    t_bad_dst();
    t_ignored();
    t_read_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule